// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers a set of interrupt sources into one pending register and one mask register, and drives a single interrupt request toward a processor core. Alongside the request it gives the index of the winning source: the unmasked pending source with the best rank. Ranks come from a per-source table that a parameter fixes, so the bit positions of the sources carry no priority meaning.

Most sources are direct. A pulse on a direct source input sets its pending bit. The bit stays set until software writes a one to it. A contiguous group of sources is instead backed by small event registers, one per source. Each event register has its own enable register. The pending bit of such a source is the OR of its enabled event bits, and it clears only when software clears those event bits. A source is latched as pending whatever its mask bit says. The mask only decides whether the pending source may reach the core, so unmasking a source that is still pending raises the request again.

Software reaches all state over a simple register bus. Reads return data one cycle after the read strobe.

Top module: `intc_masked_pend`

## Requirements
- R1: After reset, the pending register (address 0), the mask register (address 1) and every event and event-enable register read as zero, `irq_out` is 0 and `irq_vec` is 0.
- R2: A one-cycle high on `src_irq[i]` for a direct source sets pending bit i, whatever mask bit i holds. Bit i of the pending and mask registers belongs to source i.
- R3: For a direct source, writing a 1 to its pending bit clears it. Writing a 0 leaves the bit unchanged. No register write ever sets a pending bit.
- R4: `irq_out` is the registered OR of pending AND mask. It rises one clock edge after the pending bit is visible. A mask bit of 1 enables the source and a mask bit of 0 blocks it.
- R5: Clearing the mask bit of a requesting source drops `irq_out` one edge later and keeps the pending bit. Setting the mask bit again while the bit is still pending raises `irq_out` again.
- R6: Sources EVT_BASE to EVT_BASE+NUM_EVT-1 are event-backed. For the k-th of them, the event register sits at address 8+2k and the enable register at 9+2k. Event bit b is set by `evt_in[k*EVT_W+b]`, is cleared by writing a 1 to it, and is left unchanged by writing a 0. An enable bit of 1 lets the event bit count. The pending bit of the source is the OR of its enabled event bits. A direct write of 1 to that pending bit has no effect, and so does `src_irq` at that position.
- R7: `irq_vec` gives the index of the pending and unmasked source with the smallest rank, where rank(i) = (i*RANK_MUL + RANK_OFS) mod RANK_MOD. On equal ranks the lower index wins. `irq_vec` is 0 when nothing requests.
- R8: When a source event and a write of 1 clearing the same bit land in the same cycle, the event wins and the bit stays set. This holds for direct pending bits and for event register bits alike.
- R9: `bus_rdata` is registered. It holds the addressed register's value from before the edge that samples `bus_rd`. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Direct source event pulses, bit i for source i |
| evt_in | input | NUM_EVT*EVT_W | Peripheral event pulses for the event-backed sources |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after `bus_rd` |
| irq_out | output | 1 | Interrupt request to the core |
| irq_vec | output | $clog2(NUM_SRC) | Index of the winning source |

## Verification
The bench masks a source before it fires. It then checks that the source still latches, that unmasking raises the request, and that masking it again drops the request without losing the pending bit. A design that gated latching with the mask, or cleared pending bits on a mask write, would fail these checks.

The bench also collides an event with a clearing write on the same bit. A design that let the write win would drop an interrupt.

On event-backed sources, the bench tries a direct clearing write and a direct source pulse. Both must do nothing, and only enabled event bits may count toward the pending bit.

Priority is checked with ranks that differ from bit order and include ties. A selector that used bit order, or broke ties toward the higher index, would report the wrong vector.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_EVT   = 3'd3,
    SEL_EMASK = 3'd4
  } reg_sel_e;

  // Rank of a source: a smaller value means a more urgent source.
  function automatic int rank_of(input int idx, input int mul, input int ofs, input int modv);
    return (idx * mul + ofs) % modv;
  endfunction

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/intc_bus_dec.sv
module intc_bus_dec #(
  parameter int AW            = 6,
  parameter int NUM_EVT       = 4,
  parameter int EVT_ADDR_BASE = 8,
  localparam int EIW          = intc_pkg::max1($clog2(NUM_EVT))
) (
  input  logic [AW-1:0]          addr,
  output intc_pkg::reg_sel_e     sel,
  output logic [EIW-1:0]         evt_idx
);
  import intc_pkg::*;

  localparam int EVT_ADDR_END = EVT_ADDR_BASE + 2 * NUM_EVT;

  int a;
  int off;

  always_comb begin
    a       = int'(addr);
    off     = a - EVT_ADDR_BASE;
    sel     = SEL_NONE;
    evt_idx = '0;
    if (a == 0) begin
      sel = SEL_PEND;
    end else if (a == 1) begin
      sel = SEL_MASK;
    end else if (a >= EVT_ADDR_BASE && a < EVT_ADDR_END) begin
      evt_idx = EIW'(off / 2);
      sel     = (off % 2 == 1) ? SEL_EMASK : SEL_EVT;
    end
  end

endmodule

// File: rtl/intc_evt_bank.sv
module intc_evt_bank #(
  parameter int NUM_EVT = 4,
  parameter int EVT_W   = 8,
  parameter int DW      = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EVT*EVT_W-1:0] evt_in,
  input  logic [NUM_EVT-1:0]       wr_evt,
  input  logic [NUM_EVT-1:0]       wr_emask,
  input  logic [DW-1:0]            wdata,
  output logic [NUM_EVT*EVT_W-1:0] evt_q,
  output logic [NUM_EVT*EVT_W-1:0] emask_q,
  output logic [NUM_EVT-1:0]       evt_any
);

  logic [EVT_W-1:0] wbits;
  assign wbits = wdata[EVT_W-1:0];

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic [EVT_W-1:0] ev_r;
    logic [EVT_W-1:0] en_r;
    logic [EVT_W-1:0] clr;

    // A write of one clears a bit, but a new event in the same cycle keeps it set.
    assign clr = wr_evt[k] ? wbits : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        ev_r <= '0;
        en_r <= '0;
      end else begin
        ev_r <= (ev_r & ~clr) | evt_in[k*EVT_W +: EVT_W];
        if (wr_emask[k]) begin
          en_r <= wbits;
        end
      end
    end

    assign evt_q[k*EVT_W +: EVT_W]   = ev_r;
    assign emask_q[k*EVT_W +: EVT_W] = en_r;
    assign evt_any[k]                = |(ev_r & en_r);
  end

endmodule

// File: rtl/intc_pend_mask.sv
module intc_pend_mask #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_EVT  = 4,
  parameter int EVT_BASE = 8,
  parameter int DW       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [NUM_EVT-1:0] evt_any,
  input  logic               wr_pend,
  input  logic               wr_mask,
  input  logic [DW-1:0]      wdata,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] mask
);

  logic [NUM_SRC-1:0] is_evt;
  logic [NUM_SRC-1:0] evt_spread;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] clr;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pos
    if (i >= EVT_BASE && i < EVT_BASE + NUM_EVT) begin : g_evt_pos
      assign is_evt[i]     = 1'b1;
      assign evt_spread[i] = evt_any[i-EVT_BASE];
    end else begin : g_dir_pos
      assign is_evt[i]     = 1'b0;
      assign evt_spread[i] = 1'b0;
    end
  end

  assign clr = wr_pend ? wdata[NUM_SRC-1:0] : '0;

  // Direct bits: the source input takes priority over a clearing write.
  // Event-backed positions are never stored here.
  assign pend_d = ((pend_q & ~clr) | src_irq) & ~is_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_mask) begin
        mask_q <= wdata[NUM_SRC-1:0];
      end
    end
  end

  assign pend = pend_q | evt_spread;
  assign mask = mask_q;

endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel #(
  parameter int NUM_SRC  = 16,
  parameter int RANK_MUL = 7,
  parameter int RANK_OFS = 3,
  parameter int RANK_MOD = 16,
  localparam int IDXW    = intc_pkg::max1($clog2(NUM_SRC)),
  localparam int RANK_W  = intc_pkg::max1($clog2(RANK_MOD))
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDXW-1:0]    idx
);

  logic [RANK_W-1:0] rank_tab [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
    assign rank_tab[i] = RANK_W'(intc_pkg::rank_of(i, RANK_MUL, RANK_OFS, RANK_MOD));
  end

  logic [RANK_W-1:0] best_rank;

  // The strict less-than keeps the lower index when two ranks are equal.
  always_comb begin
    any       = 1'b0;
    idx       = '0;
    best_rank = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!any || rank_tab[i] < best_rank)) begin
        any       = 1'b1;
        idx       = IDXW'(i);
        best_rank = rank_tab[i];
      end
    end
  end

endmodule

// File: rtl/intc_masked_pend.sv
module intc_masked_pend #(
  parameter int NUM_SRC       = 16,
  parameter int NUM_EVT       = 4,
  parameter int EVT_BASE      = 8,
  parameter int EVT_W         = 8,
  parameter int DW            = 32,
  parameter int AW            = 6,
  parameter int EVT_ADDR_BASE = 8,
  parameter int RANK_MUL      = 7,
  parameter int RANK_OFS      = 3,
  parameter int RANK_MOD      = 16,
  localparam int IDXW         = intc_pkg::max1($clog2(NUM_SRC)),
  localparam int EIW          = intc_pkg::max1($clog2(NUM_EVT))
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       src_irq,
  input  logic [NUM_EVT*EVT_W-1:0] evt_in,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     irq_out,
  output logic [IDXW-1:0]          irq_vec
);
  import intc_pkg::*;

  reg_sel_e                 sel;
  logic [EIW-1:0]           evt_idx;
  logic [NUM_EVT-1:0]       wr_evt;
  logic [NUM_EVT-1:0]       wr_emask;
  logic [NUM_EVT-1:0]       evt_any;
  logic [NUM_EVT*EVT_W-1:0] evt_q;
  logic [NUM_EVT*EVT_W-1:0] emask_q;
  logic [NUM_SRC-1:0]       pend_w;
  logic [NUM_SRC-1:0]       mask_w;
  logic [NUM_SRC-1:0]       req;
  logic                     sel_any;
  logic [IDXW-1:0]          sel_idx;
  logic                     wr_pend;
  logic                     wr_mask;

  intc_bus_dec #(
    .AW(AW), .NUM_EVT(NUM_EVT), .EVT_ADDR_BASE(EVT_ADDR_BASE)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .evt_idx(evt_idx)
  );

  assign wr_pend = bus_wr && (sel == SEL_PEND);
  assign wr_mask = bus_wr && (sel == SEL_MASK);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_wstb
    assign wr_evt[k]   = bus_wr && (sel == SEL_EVT)   && (evt_idx == EIW'(k));
    assign wr_emask[k] = bus_wr && (sel == SEL_EMASK) && (evt_idx == EIW'(k));
  end

  intc_evt_bank #(
    .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .DW(DW)
  ) u_evt (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_evt(wr_evt),
    .wr_emask(wr_emask), .wdata(bus_wdata), .evt_q(evt_q),
    .emask_q(emask_q), .evt_any(evt_any)
  );

  intc_pend_mask #(
    .NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .EVT_BASE(EVT_BASE), .DW(DW)
  ) u_pm (
    .clk(clk), .rst(rst), .src_irq(src_irq), .evt_any(evt_any),
    .wr_pend(wr_pend), .wr_mask(wr_mask), .wdata(bus_wdata),
    .pend(pend_w), .mask(mask_w)
  );

  assign req = pend_w & mask_w;

  intc_prio_sel #(
    .NUM_SRC(NUM_SRC), .RANK_MUL(RANK_MUL), .RANK_OFS(RANK_OFS), .RANK_MOD(RANK_MOD)
  ) u_sel (
    .req(req), .any(sel_any), .idx(sel_idx)
  );

  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_PEND:  rdata_d[NUM_SRC-1:0] = pend_w;
      SEL_MASK:  rdata_d[NUM_SRC-1:0] = mask_w;
      SEL_EVT:   rdata_d[EVT_W-1:0]   = evt_q[int'(evt_idx)*EVT_W +: EVT_W];
      SEL_EMASK: rdata_d[EVT_W-1:0]   = emask_q[int'(evt_idx)*EVT_W +: EVT_W];
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      irq_vec   <= '0;
    end else begin
      if (bus_rd) begin
        bus_rdata <= rdata_d;
      end
      irq_out <= sel_any;
      irq_vec <= sel_any ? sel_idx : '0;
    end
  end

endmodule

// File: rtl/intc_masked_pend_chk.sv
module intc_masked_pend_chk #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_EVT  = 4,
  parameter int EVT_BASE = 8,
  parameter int IDXW     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_irq,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq_out,
  input logic [IDXW-1:0]    irq_vec
);

  logic [NUM_SRC-1:0] evt_pos;
  logic [NUM_SRC-1:0] req_prev;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      evt_pos[i] = (i >= EVT_BASE) && (i < EVT_BASE + NUM_EVT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_prev <= '0;
    else     req_prev <= pend & mask;
  end

  // R4: the core request tracks the unmasked pending set of the cycle before
  a_r4_req_follows: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|req_prev));

  // R7: the reported vector belongs to a source that was requesting
  a_r7_vec_requesting: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> req_prev[irq_vec]);

  // R7: with no request the vector reads zero
  a_r7_vec_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (irq_vec == '0));

  // R3: a direct pending bit only rises after its source fired
  a_r3_no_soft_set: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~evt_pos & ~$past(src_irq)) == '0);

  // R8: a direct source pulse always leaves its bit set, even against a clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (~pend & $past(src_irq) & ~evt_pos) == '0);

endmodule

bind intc_masked_pend intc_masked_pend_chk #(
  .NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .EVT_BASE(EVT_BASE), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .src_irq(src_irq), .pend(pend_w), .mask(mask_w),
  .irq_out(irq_out), .irq_vec(irq_vec)
);

// File: tb/tb_intc_masked_pend.sv
module tb_intc_masked_pend;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC  = 16;
  localparam int NUM_EVT  = 4;
  localparam int EVT_BASE = 8;
  localparam int EVT_W    = 8;
  localparam int DW       = 32;
  localparam int AW       = 6;
  localparam int RMUL     = 7;
  localparam int ROFS     = 3;
  localparam int RMOD     = 8;
  localparam int IDXW     = $clog2(NUM_SRC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_SRC-1:0]       src_irq = '0;
  logic [NUM_EVT*EVT_W-1:0] evt_in = '0;
  logic [AW-1:0]            bus_addr = '0;
  logic                     bus_wr = 1'b0;
  logic                     bus_rd = 1'b0;
  logic [DW-1:0]            bus_wdata = '0;
  logic [DW-1:0]            bus_rdata;
  logic                     irq_out;
  logic [IDXW-1:0]          irq_vec;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_masked_pend #(
    .NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .EVT_BASE(EVT_BASE), .EVT_W(EVT_W),
    .DW(DW), .AW(AW), .EVT_ADDR_BASE(8), .RANK_MUL(RMUL), .RANK_OFS(ROFS),
    .RANK_MOD(RMOD)
  ) dut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .evt_in(evt_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_src(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    src_irq = v;
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic pulse_evt(input int k, input int b);
    @(negedge clk);
    evt_in[k*EVT_W+b] = 1'b1;
    @(negedge clk);
    evt_in = '0;
  endtask

  // Expected vector from the rank rule of R7
  function automatic int exp_vec(input logic [NUM_SRC-1:0] r);
    int best = -1;
    int br = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (r[i] && (best < 0 || ((i*RMUL+ROFS)%RMOD) < br)) begin
        best = i; br = (i*RMUL+ROFS)%RMOD;
      end
    end
    return (best < 0) ? 0 : best;
  endfunction

  task automatic clear_all();
    wr(0, 32'hFFFF);
    for (int k = 0; k < NUM_EVT; k++) wr(8+2*k, 32'hFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 irq_vec", 32'(irq_vec), 0);
    rd(0, d); chk("R1 pending", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(10, d); chk("R1 event reg", d, 0);
    rd(11, d); chk("R1 event enable", d, 0);
  endtask

  task automatic t_latch_and_mask();
    logic [31:0] d;
    pulse_src(16'h0008);
    rd(0, d); chk("R2 masked source latches", d, 32'h8);
    chk("R4 masked gives no request", 32'(irq_out), 0);
    wr(1, 32'h8); tick();
    chk("R4 unmask raises request", 32'(irq_out), 1);
    chk("R4 vector", 32'(irq_vec), 3);
    wr(1, 32'h0); tick();
    chk("R5 mask drops request", 32'(irq_out), 0);
    rd(0, d); chk("R5 pending kept", d, 32'h8);
    rd(1, d); chk("R9 mask readback", d, 0);
    wr(1, 32'h8); tick();
    chk("R5 re-unmask re-raises", 32'(irq_out), 1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(0, 32'h0);
    rd(0, d); chk("R3 zero write no effect", d, 32'h8);
    wr(0, 32'h4);
    rd(0, d); chk("R3 write cannot set", d, 32'h8);
    wr(0, 32'h8);
    rd(0, d); chk("R3 one write clears", d, 0);
    tick();
    chk("R3 request gone", 32'(irq_out), 0);
  endtask

  task automatic t_priority();
    wr(1, 32'hFFFF);
    pulse_src(16'h0007); tick();
    chk("R7 ranks not bit order", 32'(irq_vec), 32'(exp_vec(16'h0007)));
    chk("R7 expected 2", 32'(irq_vec), 2);
    pulse_src(16'h0008); tick();
    chk("R7 best rank wins", 32'(irq_vec), 3);
    clear_all();
    pulse_src(16'h1010); tick();
    chk("R7 tie to lower index", 32'(irq_vec), 4);
    clear_all();
    pulse_src(16'h8020); tick();
    chk("R7 higher index by rank", 32'(irq_vec), 15);
    clear_all(); tick();
    chk("R7 idle vector zero", 32'(irq_vec), 0);
  endtask

  task automatic t_event();
    logic [31:0] d;
    pulse_evt(1, 2);
    rd(10, d); chk("R6 event latched", d, 32'h4);
    wr(11, 32'h1);
    rd(0, d); chk("R6 disabled event bit ignored", d, 0);
    wr(11, 32'h4);
    rd(0, d); chk("R6 enabled event sets pending", d, 32'h200);
    wr(0, 32'h200);
    rd(0, d); chk("R6 direct clear ignored", d, 32'h200);
    tick();
    chk("R6 event source requests", 32'(irq_vec), 9);
    wr(10, 32'h0);
    rd(10, d); chk("R6 event zero write", d, 32'h4);
    wr(10, 32'h4);
    rd(0, d); chk("R6 event clear drops pending", d, 0);
    tick();
    chk("R6 request gone", 32'(irq_out), 0);
    pulse_src(16'h0400);
    rd(0, d); chk("R6 src_irq ignored at event pos", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse_src(16'h0040);
    @(negedge clk);
    src_irq = 16'h0040; bus_addr = 0; bus_wdata = 32'h40; bus_wr = 1'b1;
    @(negedge clk);
    src_irq = '0; bus_wr = 1'b0;
    rd(0, d); chk("R8 direct event beats clear", d, 32'h40);
    pulse_evt(0, 1);
    @(negedge clk);
    evt_in[1] = 1'b1; bus_addr = 8; bus_wdata = 32'h2; bus_wr = 1'b1;
    @(negedge clk);
    evt_in = '0; bus_wr = 1'b0;
    rd(8, d); chk("R8 event reg beats clear", d, 32'h2);
    rd(63, d); chk("R9 unmapped reads zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_latch_and_mask();
    t_w1c();
    t_priority();
    clear_all();
    wr(1, 32'hFFFF);
    t_event();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule